// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between a word-wide data memory port and the register file of a processor core. On the load side it accepts the raw memory word, the low address bits, an access size, a signed flag and a runtime endianness select. It returns the register value, with the addressed byte or halfword moved to the bottom and then zero-filled or sign-filled. A word read from an address that is not a multiple of four comes back rotated, not faulted. On the store side, in the same cycle, it replicates the register's low byte or halfword across the word and raises only the byte strobes that the address and endianness select.

Both paths share one lane-mapping stage. A generate option either registers every output, giving one cycle of latency and a cleared reset state, or leaves the block purely combinational. The access size is coded 2'b00 for byte, 2'b01 for halfword and 2'b10 for word. Code 2'b11 behaves as word.

Top module: `mem_lane_align`

## Requirements
- R1: With little-endian selected (big_end_i=0), a word load (size 2'b10 or 2'b11) returns the memory word rotated right by 8 times the offset. With memory word 0x0982a22e, offsets 0, 1, 2 and 3 return 0x0982a22e, 0x2e0982a2, 0xa22e0982 and 0x82a22e09.
- R2: With big-endian selected (big_end_i=1), a word load returns the memory word rotated left by 8 times the offset, so the byte at the addressed offset lands in bits 31:24.
- R3: The byte at address offset k sits in memory-word bits [8k+7:8k] in little-endian and in bits [8(3-k)+7:8(3-k)] in big-endian. A byte load (size 2'b00) of offset 0 after a word store of 0x11223344 returns 0x44 in little-endian and 0x11 in big-endian.
- R4: Unsigned byte loads zero bits 31:8, and unsigned halfword loads zero bits 31:16.
- R5: Signed byte loads copy bit 7 into bits 31:8, and signed halfword loads copy bit 15 into bits 31:16.
- R6: A halfword load (size 2'b01) uses the aligned halfword at offset h = offset with bit 0 cleared. In little-endian the byte at h is the low byte of the result. In big-endian it is the high byte.
- R7: Store write data is the register's low byte repeated in all four lanes for byte stores, the low halfword repeated twice for halfword stores, and the register value unchanged for word stores.
- R8: Store strobes: a byte store raises the single lane of the addressed byte (mapped as in R3). A halfword store raises the two lanes of the aligned halfword. A word store raises all four strobes at any offset.
- R9: The misalignment flag is high for a halfword access at an odd offset and for a word access at a nonzero offset. It is never high for a byte access.
- R10: With the output register enabled (the default), every output reflects the inputs of the previous rising clock edge, and all outputs are zero while reset is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_word_i | input | DATA_W | Raw word read from memory |
| addr_lo_i | input | log2(DATA_W/8) | Low byte-offset bits of the address |
| size_i | input | 2 | Access size code |
| sign_i | input | 1 | Sign-fill narrow loads when high |
| big_end_i | input | 1 | Big-endian lane order when high |
| st_data_i | input | DATA_W | Register value to be stored |
| ld_data_o | output | DATA_W | Aligned and extended load result |
| st_wdata_o | output | DATA_W | Replicated store write data |
| st_be_o | output | DATA_W/8 | Byte strobes for the store |
| misalign_o | output | 1 | Access not aligned to its size |

## Verification
The load extraction and the store steering work in the same cycle from one offset, size and endianness, so an error in the shared lane map shows up on both at once. Every stimulus vector drives an independent random memory word and an independent random register value together. The bench then checks the load result, write data, strobes and flag of that one cycle against separate reference functions. A directed sequence feeds the captured store data back as the next load word, so the store lane order and the load lane order are judged against each other for both endianness settings.

// File: rtl/mla_pkg.sv
package mla_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;
endpackage

// File: rtl/mla_lane_map.sv
module mla_lane_map #(
   parameter int OFS_W = 2
) (
   input  logic [OFS_W-1:0] ofs_i,
   input  logic             big_i,
   output logic [OFS_W-1:0] byte_lane_o,
   output logic [OFS_W-2:0] half_idx_o
);
   initial assert (OFS_W >= 2) else $error("mla_lane_map: OFS_W must be at least 2");

   // big-endian mirrors the lane number; for power-of-two lanes that is an inversion
   assign byte_lane_o = big_i ? ~ofs_i : ofs_i;
   assign half_idx_o  = big_i ? ~ofs_i[OFS_W-1:1] : ofs_i[OFS_W-1:1];
endmodule

// File: rtl/mla_load_path.sv
module mla_load_path
   import mla_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]           word_i,
   input  logic [$clog2(DATA_W/8)-1:0] ofs_i,
   input  logic [1:0]                  size_i,
   input  logic                        sign_i,
   input  logic                        big_i,
   input  logic [$clog2(DATA_W/8)-1:0] byte_lane_i,
   input  logic [$clog2(DATA_W/8)-2:0] half_idx_i,
   output logic [DATA_W-1:0]           data_o,
   output logic                        misalign_o
);
   localparam int LANES  = DATA_W / 8;
   localparam int HALVES = LANES / 2;
   localparam int OFS_W  = $clog2(LANES);

   acc_size_e         sz;
   logic [7:0]        lane_b [LANES];
   logic [15:0]       lane_h [HALVES];
   logic [7:0]        sel_b;
   logic [15:0]       sel_h;
   logic [DATA_W-1:0] rot_w;

   assign sz = acc_size_e'(size_i);

   for (genvar gb = 0; gb < LANES; gb++) begin : g_bytes
      assign lane_b[gb] = word_i[8*gb +: 8];
   end
   for (genvar gh = 0; gh < HALVES; gh++) begin : g_halves
      assign lane_h[gh] = word_i[16*gh +: 16];
   end

   assign sel_b = lane_b[byte_lane_i];
   assign sel_h = lane_h[half_idx_i];

   // word rotation: right by offset lanes (little), left by offset lanes (big)
   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         logic [OFS_W-1:0] src;
         src = big_i ? (OFS_W'(i) - ofs_i) : (OFS_W'(i) + ofs_i);
         rot_w[8*i +: 8] = lane_b[src];
      end
   end

   always_comb begin
      unique case (sz)
         SZ_BYTE: data_o = {{(DATA_W-8){sign_i & sel_b[7]}}, sel_b};
         SZ_HALF: data_o = {{(DATA_W-16){sign_i & sel_h[15]}}, sel_h};
         default: data_o = rot_w;
      endcase
   end

   always_comb begin
      unique case (sz)
         SZ_BYTE: misalign_o = 1'b0;
         SZ_HALF: misalign_o = ofs_i[0];
         default: misalign_o = |ofs_i;
      endcase
   end
endmodule

// File: rtl/mla_store_path.sv
module mla_store_path
   import mla_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]           data_i,
   input  logic [1:0]                  size_i,
   input  logic [$clog2(DATA_W/8)-1:0] byte_lane_i,
   input  logic [$clog2(DATA_W/8)-2:0] half_idx_i,
   output logic [DATA_W-1:0]           wdata_o,
   output logic [DATA_W/8-1:0]         be_o
);
   localparam int LANES  = DATA_W / 8;
   localparam int HALVES = LANES / 2;
   localparam int OFS_W  = $clog2(LANES);

   acc_size_e sz;
   assign sz = acc_size_e'(size_i);

   always_comb begin
      unique case (sz)
         SZ_BYTE: wdata_o = {LANES{data_i[7:0]}};
         SZ_HALF: wdata_o = {HALVES{data_i[15:0]}};
         default: wdata_o = data_i;
      endcase
   end

   for (genvar gl = 0; gl < LANES; gl++) begin : g_be
      localparam logic [OFS_W-1:0] LANE_ID = OFS_W'(gl);
      always_comb begin
         unique case (sz)
            SZ_BYTE: be_o[gl] = (LANE_ID == byte_lane_i);
            SZ_HALF: be_o[gl] = (LANE_ID[OFS_W-1:1] == half_idx_i);
            default: be_o[gl] = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/mem_lane_align.sv
module mem_lane_align
   import mla_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1,
   localparam int LANES  = DATA_W / 8,
   localparam int OFS_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ld_word_i,
   input  logic [OFS_W-1:0]  addr_lo_i,
   input  logic [1:0]        size_i,
   input  logic              sign_i,
   input  logic              big_end_i,
   input  logic [DATA_W-1:0] st_data_i,
   output logic [DATA_W-1:0] ld_data_o,
   output logic [DATA_W-1:0] st_wdata_o,
   output logic [LANES-1:0]  st_be_o,
   output logic              misalign_o
);
   initial assert (DATA_W >= 32 && (DATA_W & (DATA_W - 1)) == 0)
      else $error("mem_lane_align: DATA_W must be a power of two of at least 32");

   logic [OFS_W-1:0]  byte_lane;
   logic [OFS_W-2:0]  half_idx;
   logic [DATA_W-1:0] ld_c, wd_c;
   logic [LANES-1:0]  be_c;
   logic              mis_c;

   mla_lane_map #(.OFS_W(OFS_W)) lane_map_i (
      .ofs_i       (addr_lo_i),
      .big_i       (big_end_i),
      .byte_lane_o (byte_lane),
      .half_idx_o  (half_idx)
   );

   mla_load_path #(.DATA_W(DATA_W)) load_i (
      .word_i      (ld_word_i),
      .ofs_i       (addr_lo_i),
      .size_i      (size_i),
      .sign_i      (sign_i),
      .big_i       (big_end_i),
      .byte_lane_i (byte_lane),
      .half_idx_i  (half_idx),
      .data_o      (ld_c),
      .misalign_o  (mis_c)
   );

   mla_store_path #(.DATA_W(DATA_W)) store_i (
      .data_i      (st_data_i),
      .size_i      (size_i),
      .byte_lane_i (byte_lane),
      .half_idx_i  (half_idx),
      .wdata_o     (wd_c),
      .be_o        (be_c)
   );

   if (OUT_REG) begin : g_reg
      logic cap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ld_data_o  <= '0;
            st_wdata_o <= '0;
            st_be_o    <= '0;
            misalign_o <= 1'b0;
            cap_q      <= 1'b0;
         end else begin
            ld_data_o  <= ld_c;
            st_wdata_o <= wd_c;
            st_be_o    <= be_c;
            misalign_o <= mis_c;
            cap_q      <= 1'b1;
         end
      end

      // R8
      be_byte_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_q && $past(size_i) == 2'b00) |-> $countones(st_be_o) == 1);
      // R8
      be_word_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_q && $past(size_i[1])) |-> &st_be_o);
      // R4
      ld_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_q && $past(size_i) == 2'b00 && !$past(sign_i)) |-> ld_data_o[DATA_W-1:8] == '0);
      // R5
      ld_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_q && $past(size_i) == 2'b00 && $past(sign_i))
            |-> ld_data_o[DATA_W-1:8] == {(DATA_W-8){ld_data_o[7]}});
      // R9
      byte_never_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_q && $past(size_i) == 2'b00) |-> !misalign_o);
      // R7
      wdata_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_q && $past(size_i) == 2'b00) |-> st_wdata_o == {LANES{st_wdata_o[7:0]}});
   end else begin : g_comb
      assign ld_data_o  = ld_c;
      assign st_wdata_o = wd_c;
      assign st_be_o    = be_c;
      assign misalign_o = mis_c;
   end
endmodule

// File: tb/mem_lane_align_tb_top.sv
`timescale 1ns/1ps
module mem_lane_align_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ld_word_i = '0;
   logic [1:0]  addr_lo_i = '0;
   logic [1:0]  size_i = '0;
   logic        sign_i = 1'b0;
   logic        big_end_i = 1'b0;
   logic [31:0] st_data_i = '0;
   logic [31:0] ld_data_o, st_wdata_o;
   logic [3:0]  st_be_o;
   logic        misalign_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mem_lane_align dut_i (
      .clk(clk), .rst_n(rst_n), .ld_word_i(ld_word_i), .addr_lo_i(addr_lo_i),
      .size_i(size_i), .sign_i(sign_i), .big_end_i(big_end_i), .st_data_i(st_data_i),
      .ld_data_o(ld_data_o), .st_wdata_o(st_wdata_o), .st_be_o(st_be_o),
      .misalign_o(misalign_o)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // memory word from address-ordered bytes (mb[8k+:8] = byte at offset k)
   function automatic logic [31:0] phys(logic [31:0] mb, logic big);
      logic [31:0] w;
      for (int k = 0; k < 4; k++) w[8*(big ? 3-k : k) +: 8] = mb[8*k +: 8];
      return w;
   endfunction

   function automatic logic [31:0] exp_load(logic [31:0] mb, int ofs, logic [1:0] sz,
                                             logic sgn, logic big);
      logic [31:0] r;
      logic [7:0]  b;
      logic [15:0] h;
      int hb;
      if (sz == 2'b00) begin
         b = mb[8*ofs +: 8];
         r = {{24{sgn & b[7]}}, b};
      end else if (sz == 2'b01) begin
         hb = ofs & 2;
         h = big ? {mb[8*hb +: 8], mb[8*(hb+1) +: 8]} : {mb[8*(hb+1) +: 8], mb[8*hb +: 8]};
         r = {{16{sgn & h[15]}}, h};
      end else begin
         for (int i = 0; i < 4; i++) r[8*(big ? 3-i : i) +: 8] = mb[8*((ofs+i)%4) +: 8];
      end
      return r;
   endfunction

   function automatic logic [31:0] exp_wd(logic [31:0] d, logic [1:0] sz);
      if (sz == 2'b00) return {4{d[7:0]}};
      if (sz == 2'b01) return {2{d[15:0]}};
      return d;
   endfunction

   function automatic logic [3:0] exp_be(int ofs, logic [1:0] sz, logic big);
      int hb;
      hb = ofs & 2;
      if (sz == 2'b00) return 4'b0001 << (big ? 3-ofs : ofs);
      if (sz == 2'b01) return 4'b0011 << (big ? 2-hb : hb);
      return 4'hf;
   endfunction

   function automatic logic exp_mis(int ofs, logic [1:0] sz);
      if (sz == 2'b00) return 1'b0;
      if (sz == 2'b01) return ofs[0];
      return ofs != 0;
   endfunction

   // drive one vector at a falling edge; results appear after the next rising edge
   task automatic run_vec(string tag, logic [31:0] mb, int ofs, logic [1:0] sz,
                          logic sgn, logic big, logic [31:0] sd);
      @(negedge clk);
      ld_word_i = phys(mb, big);
      addr_lo_i = ofs[1:0];
      size_i    = sz;
      sign_i    = sgn;
      big_end_i = big;
      st_data_i = sd;
      @(negedge clk);
      chk({tag, " load"}, ld_data_o, exp_load(mb, ofs, sz, sgn, big));
      chk("R7 wdata", st_wdata_o, exp_wd(sd, sz));
      chk("R8 strobes", {28'd0, st_be_o}, {28'd0, exp_be(ofs, sz, big)});
      chk("R9 misalign", {31'd0, misalign_o}, {31'd0, exp_mis(ofs, sz)});
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      if (!done) $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] cap;
      void'($urandom(32'd2718));
      // R10: reset holds outputs at zero even with live inputs
      ld_word_i = 32'hdeadbeef; st_data_i = 32'h12345678; size_i = 2'b00;
      repeat (3) @(negedge clk);
      chk("R10 reset ld", ld_data_o, 32'h0);
      chk("R10 reset wd", st_wdata_o, 32'h0);
      chk("R10 reset be", {28'd0, st_be_o}, 32'h0);
      chk("R10 reset mis", {31'd0, misalign_o}, 32'h0);
      rst_n = 1'b1;

      // R1 rotation vectors, little-endian
      for (int o = 0; o < 4; o++) run_vec("R1", 32'h0982a22e, o, 2'b10, 1'b0, 1'b0, 32'h0);
      chk("R1 off3 literal", ld_data_o, 32'h82a22e09);
      // R2 rotation, big-endian
      for (int o = 0; o < 4; o++) run_vec("R2", 32'h0982a22e, o, 2'b10, 1'b0, 1'b1, 32'h0);

      // R10 latency: a new input does not show before the next rising edge
      @(negedge clk);
      size_i = 2'b00; addr_lo_i = 2'd1; big_end_i = 1'b0; ld_word_i = 32'h0000ff00;
      #1 chk("R10 latency", ld_data_o, exp_load(32'h0982a22e, 3, 2'b10, 1'b0, 1'b1));

      // R3 endianness: store word, feed written data back, load byte at offset 0
      for (int be = 0; be < 2; be++) begin
         @(negedge clk);
         size_i = 2'b10; addr_lo_i = 2'd0; big_end_i = be[0]; st_data_i = 32'h11223344;
         @(negedge clk);
         cap = st_wdata_o;
         ld_word_i = cap; size_i = 2'b00; sign_i = 1'b0;
         @(negedge clk);
         chk("R3 endian byte", ld_data_o, be ? 32'h11 : 32'h44);
      end

      // R4 R5 R6 directed halfword corners
      run_vec("R5 shalf", 32'h80017f02, 2, 2'b01, 1'b1, 1'b0, 32'hcafe0123);
      run_vec("R4 uhalf", 32'h80017f02, 3, 2'b01, 1'b0, 1'b1, 32'h0);
      run_vec("R6 odd half", 32'h80017f02, 1, 2'b01, 1'b1, 1'b1, 32'h55aa);
      run_vec("R5 sbyte", 32'h000000f0, 0, 2'b00, 1'b1, 1'b0, 32'h0);
      run_vec("R1 rsvd size", 32'h0982a22e, 2, 2'b11, 1'b0, 1'b0, 32'h9);

      // constrained random mix of both paths in the same cycle
      for (int n = 0; n < 400; n++) begin
         run_vec("R1-mix R6", $urandom(), int'($urandom_range(0, 3)),
                 2'($urandom_range(0, 3)), 1'($urandom()), 1'($urandom()), $urandom());
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule